// File: doc/BRIEF.md
# Toggle-Throttled Pseudo-Random Stimulus Source

This block supplies pseudo-random stimulus to the scan chains of a logic self-test arrangement and keeps their switching activity near a programmed level. A 16-bit maximal-length shift-register generator produces one bit stream per stage. Each stream passes through its own holding register before an XOR expansion network spreads the held bits over 32 chain inputs. A separate 32-bit shift-register generator produces one pseudo-random byte per holding register each cycle. That register takes a new value only when its byte is below the 8-bit target rate, so a lower target gives longer hold runs and less toggling in the chains.

In use, the test controller loads a seed, sets the target rate and raises the enable for as many cycles as the pattern count requires. A target of 255 gives the plain pseudo-random sequence. A target of 0 freezes the stimulus. Values in between scale the average chain toggle rate.

Top module: `tr_gen_top`

## Requirements
- R1: After reset the pattern generator holds 1, every holding register holds 0 and all chain outputs are 0. The decision generator holds a fixed nonzero constant.
- R2: A seed-load cycle takes priority over enable. The pattern generator and the holding registers both take the seed, with a zero seed replaced by 1. From the next cycle the outputs show the expanded seed.
- R3: The pattern generator shifts toward its MSB with new bit 0 = s[15]^s[13]^s[12]^s[10]. It steps once per enabled cycle and is never all zero.
- R4: On an enabled cycle, holding register i takes pattern bit i as it stood before that cycle's step, if its update is granted. Otherwise it keeps its value.
- R5: Update grants come from a second, independent 32-bit generator (feedback bits 31, 21, 1, 0). Register i gets its own byte, and the grant is given when that byte is less than the target.
- R6: With target 255 every register updates on every enabled cycle. The held word then equals the pattern generator state of one cycle before.
- R7: With target 0 no register updates, so the outputs stay constant while enabled.
- R8: With enable low and no seed load, all state is kept and the outputs do not change, whatever the target.
- R9: Chain output j equals h[j mod 16] ^ h[(3j+1) mod 16] ^ h[(5j+2) mod 16], where h is the held word.
- R10: Over 10,000 enabled cycles at a fixed target T, the mean toggle rate per chain output per cycle is within 0.05 of (1-(1-T/256)^3)/2. A higher T gives a higher measured rate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Advance generators and holding registers |
| seed_load | input | 1 | Load seed into pattern generator and holding registers |
| seed | input | 16 | Seed value |
| target | input | 8 | Target update rate, out of 256 |
| chain_out | output | 32 | Expanded stimulus, one bit per scan chain |

## Verification
The assertions assume that reset is applied before use and that target and enable are steady across each clock edge. They also assume a seed load is a single-cycle event whose effect is judged on the following cycle. The stimulus changes inputs only well after an edge and holds the target fixed over each measurement window. Random seeds and targets are drawn for the transparent-sequence checks and for one rate window, alongside directed targets 0, 64, 128, 192 and 255.

// File: rtl/tr_pkg.sv
package tr_pkg;
  // Feedback mask for a left-shifting Fibonacci generator of the given width.
  function automatic logic [63:0] fb_mask(input int w);
    logic [63:0] m;
    m = '0;
    case (w)
      8:       m = 64'h0000_0000_0000_00B8;
      16:      m = 64'h0000_0000_0000_B400;
      24:      m = 64'h0000_0000_00E1_0000;
      32:      m = 64'h0000_0000_8020_0003;
      default: begin
        m[w-1] = 1'b1;
        m[w-2] = 1'b1;
      end
    endcase
    return m;
  endfunction
endpackage

// File: rtl/tr_lfsr.sv
module tr_lfsr #(
  parameter int          W    = 16,
  parameter logic [63:0] INIT = 64'd1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] state
);
  import tr_pkg::*;
  localparam logic [W-1:0] MASK  = fb_mask(W)[W-1:0];
  localparam logic [W-1:0] START = (INIT[W-1:0] == '0) ? W'(1) : INIT[W-1:0];

  logic [W-1:0] state_d;
  logic         fb;

  always_comb begin
    fb      = ^(state & MASK);
    state_d = state;
    if (load) begin
      state_d = (load_val == '0) ? W'(1) : load_val;
    end else if (step) begin
      state_d = {state[W-2:0], fb};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= START;
    end else begin
      state <= state_d;
    end
  end

  AST_STATE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    state != '0); // R3
  AST_IDLE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !step) |=> $stable(state)); // R8
endmodule

// File: rtl/tr_throttle.sv
module tr_throttle #(
  parameter int          N      = 16,
  parameter int          DEC_W  = 32,
  parameter int          RATE_W = 8,
  parameter logic [63:0] DSEED  = 64'h0000_0000_5A3C_96E1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic              load,
  input  logic [RATE_W-1:0] target,
  output logic [N-1:0]      upd
);
  localparam logic [RATE_W-1:0] FULL = '1;

  logic [DEC_W-1:0] dstate;
  logic             open_all;

  tr_lfsr #(.W(DEC_W), .INIT(DSEED)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (step),
    .load     (load),
    .load_val (DSEED[DEC_W-1:0]),
    .state    (dstate)
  );

  assign open_all = (target == FULL);

  for (genvar i = 0; i < N; i++) begin : g_reg
    logic [RATE_W-1:0] dbyte;
    for (genvar k = 0; k < RATE_W; k++) begin : g_bit
      localparam int IA = (i * 8 + k) % DEC_W;
      localparam int IB = (i * 3 + k * 5 + 7) % DEC_W;
      if (IA == IB) begin : g_one
        assign dbyte[k] = dstate[IA];
      end else begin : g_two
        assign dbyte[k] = dstate[IA] ^ dstate[IB];
      end
    end
    assign upd[i] = open_all | (dbyte < target);
  end

  AST_FULL_RATE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
    (target == FULL) |-> (upd == '1)); // R6
  AST_ZERO_RATE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
    (target == '0) |-> (upd == '0)); // R7
endmodule

// File: rtl/tr_hold_bank.sv
module tr_hold_bank #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         step,
  input  logic         load,
  input  logic [N-1:0] load_val,
  input  logic [N-1:0] upd,
  input  logic [N-1:0] src,
  output logic [N-1:0] held
);
  logic [N-1:0] held_d;
  logic [N-1:0] load_fix;

  assign load_fix = (load_val == '0) ? N'(1) : load_val;

  for (genvar i = 0; i < N; i++) begin : g_h
    always_comb begin
      held_d[i] = held[i];
      if (load) begin
        held_d[i] = load_fix[i];
      end else if (step && upd[i]) begin
        held_d[i] = src[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= '0;
    end else begin
      held <= held_d;
    end
  end

  AST_BLOCKED_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (((held ^ $past(held)) & ~$past(upd)) == '0)); // R4
  AST_PAUSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(held)); // R8
  AST_GRANT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (((held ^ $past(src)) & $past(upd)) == '0)); // R4
endmodule

// File: rtl/tr_phase_shift.sv
module tr_phase_shift #(
  parameter int N = 16,
  parameter int M = 32
) (
  input  logic [N-1:0] held,
  output logic [M-1:0] chains
);
  for (genvar j = 0; j < M; j++) begin : g_ch
    localparam int A = j % N;
    localparam int B = (3 * j + 1) % N;
    localparam int C = (5 * j + 2) % N;
    assign chains[j] = held[A] ^ held[B] ^ held[C];
  end
endmodule

// File: rtl/tr_gen_top.sv
module tr_gen_top #(
  parameter int SRC_W  = 16,
  parameter int CHAINS = 32,
  parameter int DEC_W  = 32,
  parameter int RATE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              seed_load,
  input  logic [SRC_W-1:0]  seed,
  input  logic [RATE_W-1:0] target,
  output logic [CHAINS-1:0] chain_out
);
  logic [SRC_W-1:0] pat;
  logic [SRC_W-1:0] upd;
  logic [SRC_W-1:0] held;
  logic             adv;

  assign adv = enable & ~seed_load;

  tr_lfsr #(.W(SRC_W), .INIT(64'd1)) u_pat (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (adv),
    .load     (seed_load),
    .load_val (seed),
    .state    (pat)
  );

  tr_throttle #(.N(SRC_W), .DEC_W(DEC_W), .RATE_W(RATE_W)) u_thr (
    .clk    (clk),
    .rst_n  (rst_n),
    .step   (adv),
    .load   (seed_load),
    .target (target),
    .upd    (upd)
  );

  tr_hold_bank #(.N(SRC_W)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (adv),
    .load     (seed_load),
    .load_val (seed),
    .upd      (upd),
    .src      (pat),
    .held     (held)
  );

  tr_phase_shift #(.N(SRC_W), .M(CHAINS)) u_ps (
    .held   (held),
    .chains (chain_out)
  );

  AST_LOAD_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    seed_load |=> (held == pat)); // R2
  AST_IDLE_OUT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !seed_load) |=> $stable(chain_out)); // R8
endmodule

// File: tb/tr_gen_top_tb_top.sv
module tr_gen_top_tb_top;
  logic        clk;
  logic        rst_n;
  logic        enable;
  logic        seed_load;
  logic [15:0] seed;
  logic [7:0]  target;
  logic [31:0] chain_out;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 0;

  tr_gen_top dut_i (
    .clk(clk), .rst_n(rst_n), .enable(enable), .seed_load(seed_load),
    .seed(seed), .target(target), .chain_out(chain_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: actual cycles=%0d expected<=150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [15:0] step16(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  function automatic logic [31:0] expand(input logic [15:0] h);
    logic [31:0] o;
    for (int j = 0; j < 32; j++)
      o[j] = h[j % 16] ^ h[(3 * j + 1) % 16] ^ h[(5 * j + 2) % 16];
    return o;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic do_load(input logic [15:0] s);
    seed = s; seed_load = 1'b1; enable = 1'b1;
    tick();
    seed_load = 1'b0;
  endtask

  // transparent run: R3 R4 R6 R9
  task automatic transparent_run(input logic [15:0] s, input int n);
    logic [15:0] m_pat;
    logic [15:0] m_held;
    int errs;
    do_load(s);
    m_pat  = (s == 16'h0) ? 16'h1 : s;
    m_held = m_pat;
    check("R2 seed load", chain_out, expand(m_held));
    target = 8'hFF; enable = 1'b1;
    errs = 0;
    for (int c = 0; c < n; c++) begin
      tick();
      m_held = m_pat;
      m_pat  = step16(m_pat);
      if (chain_out !== expand(m_held)) begin
        if (errs == 0)
          $display("FAIL R6 transparent cycle %0d: actual=%h expected=%h",
                   c, chain_out, expand(m_held));
        errs++;
      end
    end
    total++;
    if (errs != 0) bad++;
  endtask

  task automatic rate_run(input logic [7:0] t, output real meas);
    logic [31:0] prev;
    longint togg;
    real p, expv;
    target = t; enable = 1'b1;
    tick();
    prev = chain_out;
    togg = 0;
    for (int c = 0; c < 10000; c++) begin
      tick();
      togg += $countones(chain_out ^ prev);
      prev = chain_out;
    end
    meas = real'(togg) / (10000.0 * 32.0);
    p    = real'(t) / 256.0;
    expv = (1.0 - (1.0 - p) * (1.0 - p) * (1.0 - p)) / 2.0;
    total++;
    if (meas < expv - 0.05 || meas > expv + 0.05) begin
      bad++;
      $display("FAIL R10 target=%0d: actual rate=%f expected=%f", t, meas, expv);
    end
  endtask

  initial begin
    logic [31:0] snap;
    real r64, r128, r192, rr;
    void'($urandom(32'd4711));
    rst_n = 1'b0; enable = 1'b0; seed_load = 1'b0; seed = '0; target = 8'd128;
    #20;
    check("R1 reset output", chain_out, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    tick();
    check("R1 after release idle", chain_out, 32'h0);

    // R2: zero seed becomes 1
    do_load(16'h0000);
    check("R2 zero seed", chain_out, expand(16'h0001));
    do_load(16'hA5C3);
    check("R2 seed", chain_out, expand(16'hA5C3));

    // R7: target 0 freezes
    target = 8'h00; enable = 1'b1;
    for (int c = 0; c < 200; c++) tick();
    check("R7 frozen", chain_out, expand(16'hA5C3));

    // R8: enable low, mid target
    target = 8'd128; enable = 1'b1;
    for (int c = 0; c < 50; c++) tick();
    snap = chain_out;
    enable = 1'b0;
    for (int c = 0; c < 100; c++) tick();
    check("R8 paused", chain_out, snap);
    target = 8'hFF;
    for (int c = 0; c < 20; c++) tick();
    check("R8 paused full target", chain_out, snap);

    // R2 priority: load with enable high overrides stepping
    target = 8'hFF;
    do_load(16'h1234);
    check("R2 priority over enable", chain_out, expand(16'h1234));

    // R3 R4 R6 R9 directed and random seeds
    transparent_run(16'h0001, 300);
    transparent_run(16'hFFFF, 300);
    for (int k = 0; k < 4; k++) transparent_run(16'($urandom()), 200);

    // R10 rates and ordering, R5 grant scaling
    do_load(16'h6B1D);
    rate_run(8'd64,  r64);
    rate_run(8'd128, r128);
    rate_run(8'd192, r192);
    rate_run(8'(32 + ($urandom() % 192)), rr);
    total++;
    if (!(r64 < r128 && r128 < r192)) begin
      bad++;
      $display("FAIL R10 ordering: actual %f %f %f expected increasing", r64, r128, r192);
    end
    // R5: partial target must move some outputs but not as much as full
    total++;
    if (!(r64 > 0.0 && r64 < 0.45)) begin
      bad++;
      $display("FAIL R5 partial grant: actual=%f expected in (0,0.45)", r64);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule